// File: doc/BRIEF.md
# Bipolar Return-to-Zero Serial Word Transmitter

This block sends 32-bit avionics data words on one serial channel. The line is carried as two digital rails, one for the positive level and one for the negative level. An external line driver turns the rails into the three-level differential signal. A host loads each word as two 16-bit halves. Once both halves are present, the block replaces the top bit with a parity bit. It then shifts the word out least-significant bit first in return-to-zero form, and holds the line at zero for a programmable gap before the channel is free again.

The channel has its own parity sense (odd or even), its own gap length and its own transmit mode. In single-shot mode the word goes out once. In repeat mode the channel keeps resending the held word with the gap between copies. A word written during a transmission waits for the next word boundary. Clearing repeat mode lets the copy in flight finish, together with its gap, and then stops. The bit rate is selected between a fast setting and a setting eight times slower, both derived from the system clock.

Top module: `bprz_word_tx`

## Requirements
- R1: `line_hi` is driven for a bit value of 1 and `line_lo` for a bit value of 0. The two rails are never high in the same cycle.
- R2: Every bit cell lasts 2*H clock cycles. The active rail is high for the first H cycles, and both rails are low for the second H cycles. H is `HALF_FAST` when `cfg_slow`=0 and `HALF_FAST*SLOW_MULT` when `cfg_slow`=1.
- R3: Bits go out in index order. Word bit 0, which is `wr_data[0]` of the lower write, is sent first and word bit 31 is sent last.
- R4: A write with `wr_upper`=0 loads word bits 15:0, and a write with `wr_upper`=1 loads bits 31:16. A word starts only after both halves have been written since the last launch, in either order. On an idle channel, `busy` and the first bit appear on the second rising edge after the completing write.
- R5: Bit 31 is replaced by parity over bits 30:0. With `cfg_odd_par`=1 the 32 transmitted bits hold an odd number of ones, and with `cfg_odd_par`=0 an even number.
- R6: After bit 31, both rails stay low for G bit times, where G = max(`cfg_gap`, 4). A `cfg_gap` below 4 is treated as 4.
- R7: `busy` is high from the first bit until the gap completes. While `busy` is low, both rails are low.
- R8: With `cfg_repeat`=1 and no new word, the held word is resent with no extra idle cycles beyond the gap.
- R9: In repeat mode, a word written while a copy is in flight does not alter that copy. It is sent from the next word boundary onward.
- R10: Clearing `cfg_repeat` during a copy lets that copy and its gap finish, then `busy` falls and no further copy starts.
- R11: After reset, both rails and `busy` are low, and no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per half |
| wr_upper | input | 1 | 0 selects word bits 15:0, 1 selects bits 31:16 |
| wr_data | input | 16 | Host write data |
| cfg_odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_repeat | input | 1 | 1 = resend continuously, 0 = send once |
| cfg_slow | input | 1 | 1 = slow bit rate, 0 = fast bit rate |
| cfg_gap | input | GAP_W | Inter-word gap in bit times, minimum 4 applied |
| line_hi | output | 1 | Positive-level rail to the line driver |
| line_lo | output | 1 | Negative-level rail to the line driver |
| busy | output | 1 | Word or trailing gap in progress |

## Verification
Words are sent whose bodies have mixed, all-zero and all-one bit patterns, in both parity modes. A mixed pattern exposes a wrong bit order or a swapped half. The all-zero and all-one bodies separate odd from even parity, because only the parity bit then differs. Gaps below, at and above the minimum tell a missing clamp apart from a miscounted gap. Both rates confirm the divider choice. A repeat sequence writes a new word in mid-copy and then clears repeat mode in mid-copy. This separates boundary-aligned switching from immediate switching, and a graceful stop from an abrupt one.

// File: rtl/bprz_pkg.sv
// Package: shared constants, the transmitter state type and the parity helper.
// Assumes a 32-bit word loaded as two equal halves.
package bprz_pkg;
    localparam int WORD_W  = 32;
    localparam int HOST_W  = WORD_W / 2;
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int MIN_GAP = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    // Parity bit for bits WORD_W-2:0; odd=1 makes the total count of ones odd.
    function automatic logic body_parity(input logic [WORD_W-2:0] body, input logic odd);
        return odd ? ~(^body) : (^body);
    endfunction
endpackage

// File: rtl/bprz_tick_gen.sv
// Module: half-bit tick generator.
// Emits a one-cycle tick every HALF_FAST (or HALF_FAST*SLOW_MULT) clocks
// while run is high, and restarts from zero whenever run is low, so the
// first half cell of a word is always full length.
module bprz_tick_gen #(
    parameter int HALF_FAST = 250,
    parameter int SLOW_MULT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int HALF_SLOW = HALF_FAST * SLOW_MULT;
    localparam int CW        = $clog2(HALF_SLOW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Select the half-cell length for the active rate.
    always_comb begin
        lim  = slow ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
        tick = run && (cnt == lim);
    end

    // Count clocks within a half cell; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bprz_host_stage.sv
// Module: host staging for one word.
// Collects the two halves written by the host and flags a word as pending
// once both have arrived. The assembled word carries parity in its top bit.
// A write in the same cycle as a launch counts toward the next word.
module bprz_host_stage
    import bprz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_upper,
    input  logic [HOST_W-1:0] wr_data,
    input  logic              cfg_odd_par,
    input  logic              take,
    output logic              pending,
    output logic [WORD_W-1:0] word
);
    logic [HOST_W-1:0] low_half;
    logic [HOST_W-1:0] high_half;
    logic              low_seen;
    logic              high_seen;
    logic [WORD_W-2:0] body;

    // Latch host data and track which halves are fresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_half  <= '0;
            high_half <= '0;
            low_seen  <= 1'b0;
            high_seen <= 1'b0;
        end else begin
            if (take) begin
                low_seen  <= 1'b0;
                high_seen <= 1'b0;
            end
            if (wr_en && !wr_upper) begin
                low_half <= wr_data;
                low_seen <= 1'b1;
            end
            if (wr_en && wr_upper) begin
                high_half <= wr_data;
                high_seen <= 1'b1;
            end
        end
    end

    // Assemble the word and substitute the parity bit.
    always_comb begin
        body    = {high_half[HOST_W-2:0], low_half};
        word    = {body_parity(body, cfg_odd_par), body};
        pending = low_seen && high_seen;
    end
endmodule

// File: rtl/bprz_serializer.sv
// Module: word serializer and gap timer.
// Sends the held word LSB first as return-to-zero cells on two rails, then
// counts the inter-word gap in half-bit ticks. At each boundary it takes a
// pending word, repeats the held one, or goes idle.
module bprz_serializer
    import bprz_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pending,
    input  logic [WORD_W-1:0] word_in,
    input  logic              cfg_repeat,
    input  logic              cfg_slow,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              take,
    output logic              run,
    output logic              rate_slow,
    output logic              line_hi,
    output logic              line_lo,
    output logic              busy
);
    tx_state_e         state;
    logic [WORD_W-1:0] cur_word;
    logic [IDX_W-1:0]  bit_idx;
    logic              half_b;
    logic [GAP_W:0]    gap_cnt;
    logic [GAP_W-1:0]  gap_eff;
    logic [GAP_W:0]    gap_halves;
    logic              gap_last;
    logic              cur_bit;

    // Gap length with the minimum applied, expressed in half cells.
    always_comb begin
        gap_eff    = (cfg_gap < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : cfg_gap;
        gap_halves = {gap_eff, 1'b0};
        gap_last   = (gap_cnt == gap_halves - 1'b1);
        take       = pending && ((state == ST_IDLE) ||
                                 (state == ST_GAP && tick && gap_last));
    end

    // Sequence through idle, bit cells and gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_word  <= '0;
            bit_idx   <= '0;
            half_b    <= 1'b0;
            gap_cnt   <= '0;
            rate_slow <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pending) begin
                        cur_word  <= word_in;
                        rate_slow <= cfg_slow;
                        bit_idx   <= '0;
                        half_b    <= 1'b0;
                        state     <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (!half_b) begin
                            half_b <= 1'b1;
                        end else begin
                            half_b <= 1'b0;
                            if (bit_idx == IDX_W'(WORD_W - 1)) begin
                                gap_cnt <= '0;
                                state   <= ST_GAP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (!gap_last) begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end else if (pending) begin
                            cur_word  <= word_in;
                            rate_slow <= cfg_slow;
                            bit_idx   <= '0;
                            state     <= ST_SEND;
                        end else if (cfg_repeat) begin
                            bit_idx <= '0;
                            state   <= ST_SEND;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the rails in the first half of each cell only.
    always_comb begin
        cur_bit = cur_word[bit_idx];
        line_hi = (state == ST_SEND) && !half_b && cur_bit;
        line_lo = (state == ST_SEND) && !half_b && !cur_bit;
        busy    = (state != ST_IDLE);
        run     = busy;
    end
endmodule

// File: rtl/bprz_word_tx.sv
// Module: top of one transmit channel.
// Joins host staging, half-bit tick generation and serialization. All
// configuration inputs are assumed static while a word is in flight, except
// cfg_repeat, which may be cleared at any time.
module bprz_word_tx
    import bprz_pkg::*;
#(
    parameter int HALF_FAST = 250,
    parameter int SLOW_MULT = 8,
    parameter int GAP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_upper,
    input  logic [HOST_W-1:0] wr_data,
    input  logic              cfg_odd_par,
    input  logic              cfg_repeat,
    input  logic              cfg_slow,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              line_hi,
    output logic              line_lo,
    output logic              busy
);
    logic              take;
    logic              pending;
    logic [WORD_W-1:0] word;
    logic              run;
    logic              rate_slow;
    logic              tick;

    bprz_host_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_upper   (wr_upper),
        .wr_data    (wr_data),
        .cfg_odd_par(cfg_odd_par),
        .take       (take),
        .pending    (pending),
        .word       (word)
    );

    bprz_tick_gen #(
        .HALF_FAST(HALF_FAST),
        .SLOW_MULT(SLOW_MULT)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .slow (rate_slow),
        .tick (tick)
    );

    bprz_serializer #(
        .GAP_W(GAP_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pending   (pending),
        .word_in   (word),
        .cfg_repeat(cfg_repeat),
        .cfg_slow  (cfg_slow),
        .cfg_gap   (cfg_gap),
        .take      (take),
        .run       (run),
        .rate_slow (rate_slow),
        .line_hi   (line_hi),
        .line_lo   (line_lo),
        .busy      (busy)
    );
endmodule

// File: rtl/bprz_word_tx_chk.sv
// Checker: watches the rails and busy at the ports of one channel.
// Pulse and idle-run lengths are measured with counters, so large dividers
// unroll nothing. Assumes cfg_slow is static while busy.
module bprz_word_tx_chk #(
    parameter int HALF_FAST = 250,
    parameter int SLOW_MULT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic line_hi,
    input logic line_lo,
    input logic busy,
    input logic cfg_slow
);
    logic        act;
    logic        prev_act;
    logic        prev_busy;
    logic [31:0] act_run;
    logic [31:0] idle_run;
    logic [31:0] h_now;

    // Current half-cell length and rail activity.
    always_comb begin
        act   = line_hi || line_lo;
        h_now = cfg_slow ? 32'(HALF_FAST * SLOW_MULT) : 32'(HALF_FAST);
    end

    // Measure consecutive active and inactive cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act  <= 1'b0;
            prev_busy <= 1'b0;
            act_run   <= '0;
            idle_run  <= '0;
        end else begin
            prev_act  <= act;
            prev_busy <= busy;
            act_run   <= act ? act_run + 1'b1 : '0;
            idle_run  <= act ? '0 : idle_run + 1'b1;
        end
    end

    p_rails_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    p_pulse_half_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_act && !act) |-> (act_run == h_now));

    p_gap_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_act && act && prev_busy) |->
            ((idle_run == h_now) || (idle_run >= 32'd9 * h_now)));

    p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_hi && !line_lo));
endmodule

bind bprz_word_tx bprz_word_tx_chk #(
    .HALF_FAST(HALF_FAST),
    .SLOW_MULT(SLOW_MULT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_hi (line_hi),
    .line_lo (line_lo),
    .busy    (busy),
    .cfg_slow(cfg_slow)
);

// File: tb/bprz_word_tx_test.sv
// Directed bench: one task per scenario, each checking its own results.
module bprz_word_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int HF         = 4;
    localparam int SM         = 8;
    localparam int GW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_upper = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          cfg_odd_par = 1'b0;
    logic          cfg_repeat = 1'b0;
    logic          cfg_slow = 1'b0;
    logic [GW-1:0] cfg_gap = 8'd4;
    logic          line_hi;
    logic          line_lo;
    logic          busy;

    int vectors = 0;
    int miscmp  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bprz_word_tx #(.HALF_FAST(HF), .SLOW_MULT(SM), .GAP_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_upper(wr_upper),
        .wr_data(wr_data), .cfg_odd_par(cfg_odd_par), .cfg_repeat(cfg_repeat),
        .cfg_slow(cfg_slow), .cfg_gap(cfg_gap),
        .line_hi(line_hi), .line_lo(line_lo), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic odd);
        return {odd ? ~(^w[30:0]) : (^w[30:0]), w[30:0]};
    endfunction

    function automatic int gap_cycles(input int h, input int g);
        return h + 2 * (g < 4 ? 4 : g) * h;
    endfunction

    task automatic write_half(input logic up, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_upper = up; wr_data = d;
    endtask

    task automatic write_word(input logic [31:0] w);
        write_half(1'b0, w[15:0]);
        write_half(1'b1, w[31:16]);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Capture one word from the rails; bad counts overlaps and wrong pulse lengths.
    task automatic recv_word(input int h, output logic [31:0] w, output int bad);
        w = '0; bad = 0;
        for (int i = 0; i < 32; i++) begin
            int cnt;
            while (!(line_hi || line_lo)) @(negedge clk);
            w[i] = line_hi;
            if (line_hi && line_lo) bad++;
            cnt = 0;
            while (line_hi || line_lo) begin
                cnt++;
                @(negedge clk);
            end
            if (cnt != h) bad++;
        end
    endtask

    // Count quiet busy cycles after a word; fell tells whether busy dropped.
    task automatic measure_gap(output int n, output bit fell);
        n = 0;
        while (busy && !(line_hi || line_lo)) begin
            n++;
            @(negedge clk);
        end
        fell = !busy;
    endtask

    task automatic stay_quiet(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy || line_hi || line_lo) seen++;
        end
        chk(seen == 0, req, "channel stays quiet", 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!line_hi && !line_lo && !busy, "R11", "outputs in reset",
            {29'd0, line_hi, line_lo, busy}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        stay_quiet(20, "R11");
    endtask

    task automatic t_single(input logic [31:0] w, input logic odd, input int g,
                            input logic slow);
        logic [31:0] got;
        int bad, n, h;
        bit fell;
        h = slow ? HF * SM : HF;
        cfg_odd_par = odd; cfg_gap = GW'(g); cfg_slow = slow; cfg_repeat = 1'b0;
        write_word(w);
        chk(!busy, "R4", "not started at completing write", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(busy && (line_hi || line_lo), "R4", "start two edges after write",
            {30'd0, busy, line_hi || line_lo}, 32'd3);
        recv_word(h, got, bad);
        chk(got == expect_word(w, odd), "R3 R5", "word bits and parity",
            got, expect_word(w, odd));
        chk(bad == 0, "R1 R2", "rail pulses", 32'(bad), 32'd0);
        measure_gap(n, fell);
        chk(n == gap_cycles(h, g), "R6", "gap length", 32'(n), 32'(gap_cycles(h, g)));
        chk(fell, "R7", "busy falls after gap", {31'd0, fell}, 32'd1);
        stay_quiet(300, "R7");
    endtask

    task automatic t_half_write;
        logic [31:0] got;
        int bad, seen;
        cfg_odd_par = 1'b1; cfg_gap = 8'd4; cfg_slow = 1'b0; cfg_repeat = 1'b0;
        write_half(1'b1, 16'h3C5A);
        @(negedge clk);
        wr_en = 1'b0;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, "R4", "one half does not start", 32'(seen), 32'd0);
        write_half(1'b0, 16'h9601);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(busy, "R4", "upper-then-lower starts", {31'd0, busy}, 32'd1);
        recv_word(HF, got, bad);
        chk(got == expect_word(32'h3C5A9601, 1'b1), "R4", "halves placed",
            got, expect_word(32'h3C5A9601, 1'b1));
        while (busy) @(negedge clk);
    endtask

    task automatic t_repeat;
        logic [31:0] got, wa, wb;
        int bad, n;
        bit fell;
        wa = 32'h0F0F1234; wb = 32'h8421C3E7;
        cfg_odd_par = 1'b0; cfg_gap = 8'd6; cfg_slow = 1'b0; cfg_repeat = 1'b1;
        write_word(wa);
        recv_word(HF, got, bad);
        chk(got == expect_word(wa, 1'b0), "R8", "first copy", got, expect_word(wa, 1'b0));
        measure_gap(n, fell);
        chk(n == gap_cycles(HF, 6) && !fell, "R8", "repeat spacing",
            32'(n), 32'(gap_cycles(HF, 6)));
        fork
            recv_word(HF, got, bad);
            begin
                repeat (40) @(negedge clk);
                write_word(wb);
            end
        join
        chk(got == expect_word(wa, 1'b0), "R9", "copy in flight unchanged",
            got, expect_word(wa, 1'b0));
        measure_gap(n, fell);
        recv_word(HF, got, bad);
        chk(got == expect_word(wb, 1'b0), "R9", "new word at boundary",
            got, expect_word(wb, 1'b0));
        measure_gap(n, fell);
        chk(!fell, "R8", "repeat continues", {31'd0, fell}, 32'd0);
        fork
            recv_word(HF, got, bad);
            begin
                repeat (40) @(negedge clk);
                cfg_repeat = 1'b0;
            end
        join
        chk(got == expect_word(wb, 1'b0) && bad == 0, "R10", "last copy completes",
            got, expect_word(wb, 1'b0));
        measure_gap(n, fell);
        chk(fell && n == gap_cycles(HF, 6), "R10", "stop after gap",
            32'(n), 32'(gap_cycles(HF, 6)));
        stay_quiet(300, "R10");
    endtask

    initial begin
        t_reset();
        t_single(32'h12345678, 1'b0, 4, 1'b0);
        t_single(32'hA5C30F01, 1'b1, 10, 1'b0);
        t_single(32'h00000000, 1'b1, 1, 1'b0);
        t_single(32'h7FFFFFFF, 1'b0, 5, 1'b1);
        t_half_write();
        t_repeat();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, miscmp + 1);
        $finish;
    end
endmodule